// File: doc/BRIEF.md
# UART Receive Queue with Per-Byte Error Tags

This block sits between a UART's serial receiver and its CPU register interface. For each completed character the receiver sends one strobe carrying the byte and three flags: parity error, framing error and break. The block queues the byte and its flags together in one 11-bit entry, 16 entries deep by default. It gives the CPU the byte at the head of the queue, the receive-side line status bits and the fill count.

The parity, framing and break status bits describe the head entry only. As the CPU reads bytes, these flags move forward with the data. A break that lasts several character times is stored once, as a zero byte. A character that arrives while the queue is full is discarded and an overrun is latched, so the bytes already queued are not lost. A summary error bit shows that some entry still in the queue has an error. It uses a running count of such entries, so it clears when the last of them is read out. It also clears when the status register is read.

Top module: `rxq_top`

## Requirements
- R1: While reset is asserted, and after it is released, the queue is empty: fill count 0, ready 0, head byte 0, and all status bits 0.
- R2: An accepted character is appended at the tail. The fill count rises by one in the cycle after the strobe. Bytes leave in arrival order. Ready is 1 exactly when the fill count is nonzero.
- R3: A data-register read strobe removes the head entry in the next cycle. A read strobe on an empty queue changes nothing: the count stays 0.
- R4: The parity, framing and break status outputs equal the flags stored with the current head entry. All three are 0 when the queue is empty.
- R5: A break character is stored with data byte 0x00 and its break flag set. Further break strobes add no entry until a strobe without the break flag arrives.
- R6: A character strobe on a full queue, without a data read in the same cycle, sets overrun. The byte is dropped, the count stays at the depth, and the queued bytes come out unchanged.
- R7: Overrun stays set until a status-register read, and it is 0 in the cycle after that read. If a new overrun event happens in the same cycle as the read, overrun stays set.
- R8: A character strobe and a data read in the same cycle on a full queue are both accepted. Overrun is not set, the count stays at the depth, and the new byte joins the tail.
- R9: The summary error bit becomes 1 in the cycle after an entry with any error flag is accepted. It becomes 0 after a status-register read. It also becomes 0 when a data read removes the last queued entry that carries an error flag.
- R10: The head-byte output is 0x00 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| char_valid | input | 1 | One-cycle strobe from the receiver: a character has completed |
| char_data | input | 8 | Received byte |
| char_perr | input | 1 | Parity error flag of the character |
| char_ferr | input | 1 | Framing error flag of the character |
| char_brk | input | 1 | Break flag: the line was low for a whole frame |
| rd_data | input | 1 | CPU read of the receive data register (pop) |
| rd_status | input | 1 | CPU read of the line status register |
| head_data | output | 8 | Byte at the head of the queue, 0 when empty |
| st_ready | output | 1 | At least one byte is queued |
| st_overrun | output | 1 | Sticky overrun |
| st_perr | output | 1 | Parity error of the head entry |
| st_ferr | output | 1 | Framing error of the head entry |
| st_brk | output | 1 | Break flag of the head entry |
| st_fifo_err | output | 1 | Summary error: an errored entry is in the queue |
| fill_count | output | 5 | Number of queued entries, 0 to depth |

## Verification
Each result comes from a register that updates at the clock edge that ends a strobe cycle. That edge is the first edge after the inputs are driven. The count, the head byte, the head flags, overrun and the summary error bit are therefore all due one cycle after the strobe. Asynchronous reset clears the outputs at once, with no clock. The bench drives each stimulus on a falling edge and lets one rising edge pass. It samples every output on the next falling edge, before the next stimulus is applied. Properties use the same one-cycle window with |=> between the strobe and its result.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DATA_W = 8;

  // one queue entry: byte plus its receive error tags
  typedef struct packed {
    logic                  brk;
    logic                  ferr;
    logic                  perr;
    logic [RXQ_DATA_W-1:0] data;
  } rxq_entry_t;

  localparam int unsigned RXQ_ENTRY_W = $bits(rxq_entry_t);
endpackage

// File: rtl/rxq_admit.sv
module rxq_admit
  import rxq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  char_valid,
  input  logic [RXQ_DATA_W-1:0] char_data,
  input  logic                  char_perr,
  input  logic                  char_ferr,
  input  logic                  char_brk,
  input  logic                  full,
  input  logic                  pop,
  output logic                  push,
  output logic                  overrun_evt,
  output rxq_entry_t            entry
);
  logic brk_hold_q, brk_hold_d;
  logic push_req;

  always_comb begin
    // a repeated break frame is not a new character
    push_req    = char_valid && !(char_brk && brk_hold_q);
    push        = push_req && (!full || pop);
    overrun_evt = push_req && full && !pop;
    entry.brk   = char_brk;
    entry.ferr  = char_ferr;
    entry.perr  = char_perr;
    entry.data  = char_brk ? '0 : char_data;
    brk_hold_d  = brk_hold_q;
    if (char_valid) begin
      brk_hold_d = char_brk ? (brk_hold_q || push) : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_hold_q <= 1'b0;
    else        brk_hold_q <= brk_hold_d;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  rxq_entry_t   wr_entry,
  output rxq_entry_t   head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rxq_entry_t      mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; the head is masked while empty
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wr_entry;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/rxq_status.sv
module rxq_status #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  logic in_err,
  input  logic head_err,
  input  logic overrun_evt,
  input  logic rd_status,
  output logic overrun,
  output logic fifo_err
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0] ecnt_q, ecnt_d;
  logic          ovr_q, ovr_d, ferr_q, ferr_d;
  logic          err_in;

  always_comb begin
    err_in = push && in_err;
    ecnt_d = ecnt_q + CW'(err_in) - CW'(pop && head_err);
    // a new event wins over the clearing read
    ovr_d  = overrun_evt ? 1'b1 : (rd_status ? 1'b0 : ovr_q);
    if (err_in)                            ferr_d = 1'b1;
    else if (rd_status || ecnt_d == '0)    ferr_d = 1'b0;
    else                                   ferr_d = ferr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      ecnt_q <= ecnt_d;
      ovr_q  <= ovr_d;
      ferr_q <= ferr_d;
    end
  end

  assign overrun  = ovr_q;
  assign fifo_err = ferr_q;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        char_valid,
  input  logic [7:0]                  char_data,
  input  logic                        char_perr,
  input  logic                        char_ferr,
  input  logic                        char_brk,
  input  logic                        rd_data,
  input  logic                        rd_status,
  output logic [7:0]                  head_data,
  output logic                        st_ready,
  output logic                        st_overrun,
  output logic                        st_perr,
  output logic                        st_ferr,
  output logic                        st_brk,
  output logic                        st_fifo_err,
  output logic [$clog2(DEPTH+1)-1:0]  fill_count
);
  logic       rst_meta_q, rst_sync_q;
  logic       push, pop, overrun_evt, full, empty;
  rxq_entry_t wr_entry, head;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign pop = rd_data && !empty;

  rxq_admit u_admit (
    .clk(clk), .rst_n(rst_sync_q),
    .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .full(full), .pop(pop),
    .push(push), .overrun_evt(overrun_evt), .entry(wr_entry)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_q),
    .push(push), .pop(pop), .wr_entry(wr_entry),
    .head(head), .count(fill_count), .full(full), .empty(empty)
  );

  rxq_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_sync_q),
    .push(push), .pop(pop),
    .in_err(wr_entry.perr || wr_entry.ferr || wr_entry.brk),
    .head_err(head.perr || head.ferr || head.brk),
    .overrun_evt(overrun_evt), .rd_status(rd_status),
    .overrun(st_overrun), .fifo_err(st_fifo_err)
  );

  assign st_ready  = !empty;
  assign head_data = empty ? 8'h00 : head.data;
  assign st_perr   = !empty && head.perr;
  assign st_ferr   = !empty && head.ferr;
  assign st_brk    = !empty && head.brk;
endmodule

// File: rtl/rxq_check.sv
module rxq_check #(
  parameter int unsigned DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       char_valid,
  input logic                       char_brk,
  input logic                       rd_data,
  input logic                       rd_status,
  input logic [7:0]                 head_data,
  input logic                       st_ready,
  input logic                       st_overrun,
  input logic                       st_perr,
  input logic                       st_ferr,
  input logic                       st_brk,
  input logic                       st_fifo_err,
  input logic [$clog2(DEPTH+1)-1:0] fill_count
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= FULL_C);

  p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !char_brk && fill_count < FULL_C && !rd_data
    |=> fill_count == $past(fill_count) + 1'b1);

  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count == '0 && rd_data && !char_valid |=> fill_count == '0);

  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> !st_perr && !st_ferr && !st_brk && head_data == 8'h00);

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !char_brk && fill_count == FULL_C && !rd_data
    |=> st_overrun && fill_count == FULL_C);

  p_ovr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !char_valid |=> !st_overrun);

  p_full_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !char_brk && fill_count == FULL_C && rd_data && !st_overrun
    |=> !st_overrun && fill_count == FULL_C);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !char_valid |=> !st_fifo_err);
endmodule

bind rxq_top rxq_check #(.DEPTH(DEPTH)) u_rxq_check (
  .clk(clk), .rst_n(rst_sync_q),
  .char_valid(char_valid), .char_brk(char_brk),
  .rd_data(rd_data), .rd_status(rd_status),
  .head_data(head_data), .st_ready(st_ready), .st_overrun(st_overrun),
  .st_perr(st_perr), .st_ferr(st_ferr), .st_brk(st_brk),
  .st_fifo_err(st_fifo_err), .fill_count(fill_count)
);

// File: tb/rxq_top_bench.sv
module rxq_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_valid = 1'b0, char_perr = 1'b0, char_ferr = 1'b0, char_brk = 1'b0;
  logic [7:0] char_data = 8'h00;
  logic       rd_data = 1'b0, rd_status = 1'b0;
  logic [7:0] head_data;
  logic       st_ready, st_overrun, st_perr, st_ferr, st_brk, st_fifo_err;
  logic [4:0] fill_count;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  rxq_top u_rxq_top (
    .clk(clk), .rst_n(rst_n),
    .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .rd_data(rd_data), .rd_status(rd_status),
    .head_data(head_data), .st_ready(st_ready), .st_overrun(st_overrun),
    .st_perr(st_perr), .st_ferr(st_ferr), .st_brk(st_brk),
    .st_fifo_err(st_fifo_err), .fill_count(fill_count)
  );

  typedef struct packed {
    logic       v, b, pe, fe;
    logic [7:0] d;
    logic       rdd, rds;
    logic [4:0] cnt;
    logic       rdy;
    logic [7:0] hd;
    logic       xpe, xfe, xbk, xov, xer;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,8'h41, 0,0, 5'd1,1,8'h41, 0,0,0,0,0},  // R2 first byte
    '{1,0,1,0,8'h52, 0,0, 5'd2,1,8'h41, 0,0,0,0,1},  // R4 R9 parity byte behind clean head
    '{1,0,0,1,8'h63, 0,0, 5'd3,1,8'h41, 0,0,0,0,1},  // R4 framing byte queued
    '{0,0,0,0,8'h00, 1,0, 5'd2,1,8'h52, 1,0,0,0,1},  // R3 R4 parity flag at head
    '{0,0,0,0,8'h00, 0,1, 5'd2,1,8'h52, 1,0,0,0,0},  // R9 status read clears summary
    '{0,0,0,0,8'h00, 1,0, 5'd1,1,8'h63, 0,1,0,0,0},  // R4 framing flag at head
    '{0,0,0,0,8'h00, 1,0, 5'd0,0,8'h00, 0,0,0,0,0},  // R10 empty head is zero
    '{0,0,0,0,8'h00, 1,0, 5'd0,0,8'h00, 0,0,0,0,0},  // R3 read on empty ignored
    '{1,1,0,1,8'h77, 0,0, 5'd1,1,8'h00, 0,1,1,0,1},  // R5 break stored as zero
    '{1,1,0,1,8'h00, 0,0, 5'd1,1,8'h00, 0,1,1,0,1},  // R5 repeated break dropped
    '{1,1,0,1,8'h00, 0,0, 5'd1,1,8'h00, 0,1,1,0,1},  // R5 still one entry
    '{1,0,0,0,8'h15, 0,0, 5'd2,1,8'h00, 0,1,1,0,1},  // R2 clean byte after break
    '{0,0,0,0,8'h00, 1,0, 5'd1,1,8'h15, 0,0,0,0,0},  // R9 last errored entry popped
    '{0,0,0,0,8'h00, 1,0, 5'd0,0,8'h00, 0,0,0,0,0}   // R3 drained
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic v, input logic b, input logic pe, input logic fe,
                      input logic [7:0] d, input logic rdd, input logic rds);
    char_valid = v; char_brk = b; char_perr = pe; char_ferr = fe;
    char_data = d; rd_data = rdd; rd_status = rds;
    @(posedge clk);
    @(negedge clk);
    char_valid = 1'b0; char_brk = 1'b0; char_perr = 1'b0; char_ferr = 1'b0;
    char_data = 8'h00; rd_data = 1'b0; rd_status = 1'b0;
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, fill_count, 0);
    chk(tag, st_ready, 0);
    chk(tag, head_data, 0);
    chk(tag, {st_overrun, st_perr, st_ferr, st_brk, st_fifo_err}, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 after release");

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].v, VECS[i].b, VECS[i].pe, VECS[i].fe, VECS[i].d,
           VECS[i].rdd, VECS[i].rds);
      chk($sformatf("vector %0d count", i), fill_count, VECS[i].cnt);
      chk($sformatf("vector %0d ready", i), st_ready, VECS[i].rdy);
      chk($sformatf("vector %0d head", i), head_data, VECS[i].hd);
      chk($sformatf("vector %0d flags", i), {st_perr, st_ferr, st_brk},
          {VECS[i].xpe, VECS[i].xfe, VECS[i].xbk});
      chk($sformatf("vector %0d overrun", i), st_overrun, VECS[i].xov);
      chk($sformatf("vector %0d summary", i), st_fifo_err, VECS[i].xer);
    end

    // fill to the depth
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 8'(i), 0, 0);
    chk("R2 full count", fill_count, 16);
    chk("R2 full head", head_data, 0);
    // R8 push and pop together on a full queue
    step(1, 0, 0, 0, 8'h90, 1, 0);
    chk("R8 count", fill_count, 16);
    chk("R8 head", head_data, 1);
    chk("R8 no overrun", st_overrun, 0);
    // R6 push on full without a read
    step(1, 0, 0, 0, 8'hEE, 0, 0);
    chk("R6 overrun", st_overrun, 1);
    chk("R6 count", fill_count, 16);
    chk("R6 head", head_data, 1);
    // R7 read plus a new overrun keeps it set, a plain read clears it
    step(1, 0, 0, 0, 8'hEF, 0, 1);
    chk("R7 set wins", st_overrun, 1);
    step(0, 0, 0, 0, 8'h00, 0, 1);
    chk("R7 cleared", st_overrun, 0);
    // R6 contents intact and in order, with the swapped byte last
    for (int k = 0; k < 16; k++) begin
      chk($sformatf("R6 drain %0d", k), head_data, (k < 15) ? k + 1 : 8'h90);
      step(0, 0, 0, 0, 8'h00, 1, 0);
    end
    chk("R6 drained", fill_count, 0);

    // R1 asynchronous reset in mid operation
    step(1, 0, 1, 0, 8'h33, 0, 0);
    chk("R1 pre-reset count", fill_count, 1);
    #2 rst_n = 1'b0;
    #1;
    chk_idle("R1 async clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1 second release");

    finish_run();
  end
endmodule